// File: doc/BRIEF.md
# Iterative Multi-Mode Integer Divider

This unit divides one operand set over a sequence of single-cycle iterations. An outside loop controller issues the operation with `start_i` and then pulses `step_i` once for each iteration. A complete divide takes one issue cycle and eighteen steps. Idle cycles between steps are allowed. All partial state is kept in registers, so a sequence that is held between steps picks up where it stopped.

The first step takes magnitudes, extends the dividend and detects a zero divisor or an early overflow. The next sixteen steps each yield one quotient bit with a restoring shift-subtract cell. The last step fixes the signs and writes the quotient and remainder registers. The five operations are signed and unsigned 32/16 divides, signed and unsigned 16/16 divides, and a signed Q15 fractional divide. The 16/16 and fractional operations share the 32/16 datapath by shaping the dividend before the first step.

Top module: `div_iter`

## Requirements
- R1: After reset, `quot_o` and `rem_o` are 0 and `done_o`, `ovf_o` and `dbz_o` are low. No step has an effect until a `start_i` is seen.
- R2: `start_i` captures `mode_i`, `dvd_lo_i`, `dvd_hi_i` and `dvs_i`, and clears `done_o`, `ovf_o` and `dbz_o` one cycle later. Operand inputs have no effect at any other time. `start_i` has priority over `step_i` in the same cycle. A new `start_i` abandons a sequence that is still running.
- R3: `done_o` rises in the cycle after the 18th `step_i` that follows `start_i`, and never earlier. Cycles without `step_i` do not advance the sequence, however many there are.
- R4: mode 0 is a signed 32/16 divide of {`dvd_hi_i`,`dvd_lo_i`} by `dvs_i`. The quotient is truncated toward zero and the remainder carries the sign of the dividend.
- R5: mode 1 is an unsigned 32/16 divide of {`dvd_hi_i`,`dvd_lo_i`} by `dvs_i`. Modes 5 to 7 behave as mode 1.
- R6: mode 2 is a signed 16/16 divide of the sign-extended `dvd_lo_i`. Mode 3 is an unsigned 16/16 divide of the zero-extended `dvd_lo_i`. In both modes `dvd_hi_i` is ignored.
- R7: mode 4 is a signed Q15 fractional divide. The quotient is `dvd_lo_i`·2^15/`dvs_i`, truncated, and the remainder is that of the scaled dividend.
- R8: `ovf_o` is set with `done_o` when the quotient does not fit in 16 bits for the mode (signed −32768..32767, unsigned 0..65535). In mode 4 it is also set when |`dvd_lo_i`| ≥ |`dvs_i`|. On overflow, `quot_o` and `rem_o` keep their previous values.
- R9: a zero divisor sets `dbz_o` with `done_o` after the 18th step, keeps `ovf_o` low and leaves `quot_o` and `rem_o` unchanged.
- R10: after completion, further `step_i` pulses change nothing. Outputs hold until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Issue: capture operands and mode, restart sequence |
| step_i | input | 1 | Advance one iteration |
| mode_i | input | 3 | Operation select (0 s32/16, 1 u32/16, 2 s16/16, 3 u16/16, 4 Q15 frac) |
| dvd_lo_i | input | 16 | Dividend low word (the whole dividend in 16-bit modes) |
| dvd_hi_i | input | 16 | Dividend high word |
| dvs_i | input | 16 | Divisor |
| quot_o | output | 16 | Quotient result register |
| rem_o | output | 16 | Remainder result register |
| done_o | output | 1 | Sequence complete |
| ovf_o | output | 1 | Quotient overflow |
| dbz_o | output | 1 | Divisor was zero |

## Verification
The bench runs every mode with random operands. The dividend high words are drawn from three ranges: fully random, near zero and near all-ones. This separates correct quotients from the overflow path and from sign-extension mistakes. The four sign combinations in the signed modes distinguish truncation from flooring and show which operand the remainder takes its sign from. The runs are repeated with random idle gaps between steps and with the operand inputs scrambled after issue. A run stepped only seventeen times checks that the sequence neither completes early nor depends on the operand inputs after issue. The extreme cases are −32768/−1, −2^31/−1, all-ones over one, a zero divisor, and fractional operands of equal magnitude; they probe the limits of the overflow rules.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [2:0] {
    MD_S32  = 3'd0,
    MD_U32  = 3'd1,
    MD_S16  = 3'd2,
    MD_U16  = 3'd3,
    MD_FRAC = 3'd4
  } div_mode_e;
endpackage

// File: rtl/div_prep.sv
module div_prep import div_pkg::*; #(
  parameter int DW = 16
) (
  input  logic [2:0]      mode_i,
  input  logic [DW-1:0]   lo_i,
  input  logic [DW-1:0]   hi_i,
  input  logic [DW-1:0]   dvs_i,
  output logic [2*DW-1:0] num_mag_o,
  output logic [DW-1:0]   dvs_mag_o,
  output logic            neg_q_o,
  output logic            neg_r_o,
  output logic            sgn_o,
  output logic            early_ovf_o,
  output logic            dbz_o
);
  localparam int NW = 2 * DW;

  logic [NW-1:0] full, lo_sx;
  logic [DW-1:0] lo_mag;
  logic          is_frac, n_neg, d_neg;

  assign lo_sx   = {{DW{lo_i[DW-1]}}, lo_i};
  assign is_frac = (mode_i == MD_FRAC);

  always_comb begin
    unique case (mode_i)
      MD_S32:  begin full = {hi_i, lo_i};          sgn_o = 1'b1; end
      MD_S16:  begin full = lo_sx;                 sgn_o = 1'b1; end
      MD_U16:  begin full = {{DW{1'b0}}, lo_i};    sgn_o = 1'b0; end
      MD_FRAC: begin full = lo_sx << (DW - 1);     sgn_o = 1'b1; end
      default: begin full = {hi_i, lo_i};          sgn_o = 1'b0; end
    endcase
  end

  assign n_neg     = sgn_o & full[NW-1];
  assign d_neg     = sgn_o & dvs_i[DW-1];
  assign num_mag_o = n_neg ? (~full + 1'b1) : full;
  assign dvs_mag_o = d_neg ? (~dvs_i + 1'b1) : dvs_i;
  assign lo_mag    = lo_i[DW-1] ? (~lo_i + 1'b1) : lo_i;
  assign neg_q_o   = n_neg ^ d_neg;
  assign neg_r_o   = n_neg;
  assign dbz_o     = (dvs_i == '0);
  // high half not below divisor: quotient needs more than DW bits
  assign early_ovf_o = (num_mag_o[NW-1:DW] >= dvs_mag_o) ||
                       (is_frac && (lo_mag >= dvs_mag_o));
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] rem_i,
  input  logic [DW-1:0] quo_i,
  input  logic [DW-1:0] dvs_i,
  output logic [DW-1:0] rem_o,
  output logic [DW-1:0] quo_o
);
  logic [DW:0] trial, diff;
  logic        ge;

  assign trial = {rem_i, quo_i[DW-1]};
  assign ge    = (trial >= {1'b0, dvs_i});
  assign diff  = trial - {1'b0, dvs_i};
  assign rem_o = ge ? diff[DW-1:0] : trial[DW-1:0];
  assign quo_o = {quo_i[DW-2:0], ge};
endmodule

// File: rtl/div_fix.sv
module div_fix #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] quo_mag_i,
  input  logic [DW-1:0] rem_mag_i,
  input  logic          neg_q_i,
  input  logic          neg_r_i,
  input  logic          sgn_i,
  output logic [DW-1:0] quo_o,
  output logic [DW-1:0] rem_o,
  output logic          late_ovf_o
);
  localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};

  assign quo_o      = neg_q_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
  assign rem_o      = neg_r_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
  assign late_ovf_o = sgn_i && (neg_q_i ? (quo_mag_i > HALF) : quo_mag_i[DW-1]);
endmodule

// File: rtl/div_iter.sv
module div_iter #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          step_i,
  input  logic [2:0]    mode_i,
  input  logic [15:0]   dvd_lo_i,
  input  logic [15:0]   dvd_hi_i,
  input  logic [15:0]   dvs_i,
  output logic [15:0]   quot_o,
  output logic [15:0]   rem_o,
  output logic          done_o,
  output logic          ovf_o,
  output logic          dbz_o
);
  localparam int STEPS = DW + 2;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] C_PREP = '0;
  localparam logic [CW-1:0] C_LAST = CW'(DW + 1);
  localparam logic [CW-1:0] C_IDLE = CW'(STEPS);

  // captured operands
  logic [2:0]    mode_q;
  logic [DW-1:0] lo_q, hi_q, dvs_q;
  // iteration state
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] rem_q, quo_q, dmag_q;
  logic          negq_q, negr_q, sgn_q, ovfp_q, dbzp_q;
  // results
  logic [DW-1:0] quot_q, remr_q;
  logic          done_q, ovf_q, dbz_q;

  logic [2*DW-1:0] p_num;
  logic [DW-1:0]   p_dmag, s_rem, s_quo, f_quo, f_rem;
  logic            p_negq, p_negr, p_sgn, p_eovf, p_dbz, f_lovf;

  div_prep #(.DW(DW)) u_prep (
    .mode_i(mode_q), .lo_i(lo_q), .hi_i(hi_q), .dvs_i(dvs_q),
    .num_mag_o(p_num), .dvs_mag_o(p_dmag), .neg_q_o(p_negq), .neg_r_o(p_negr),
    .sgn_o(p_sgn), .early_ovf_o(p_eovf), .dbz_o(p_dbz)
  );

  div_step #(.DW(DW)) u_step (
    .rem_i(rem_q), .quo_i(quo_q), .dvs_i(dmag_q), .rem_o(s_rem), .quo_o(s_quo)
  );

  div_fix #(.DW(DW)) u_fix (
    .quo_mag_i(quo_q), .rem_mag_i(rem_q), .neg_q_i(negq_q), .neg_r_i(negr_q),
    .sgn_i(sgn_q), .quo_o(f_quo), .rem_o(f_rem), .late_ovf_o(f_lovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0; lo_q <= '0; hi_q <= '0; dvs_q <= '0;
      cnt_q  <= C_IDLE;
      rem_q  <= '0; quo_q <= '0; dmag_q <= '0;
      negq_q <= 1'b0; negr_q <= 1'b0; sgn_q <= 1'b0; ovfp_q <= 1'b0; dbzp_q <= 1'b0;
      quot_q <= '0; remr_q <= '0;
      done_q <= 1'b0; ovf_q <= 1'b0; dbz_q <= 1'b0;
    end else if (start_i) begin
      mode_q <= mode_i; lo_q <= dvd_lo_i[DW-1:0]; hi_q <= dvd_hi_i[DW-1:0];
      dvs_q  <= dvs_i[DW-1:0];
      cnt_q  <= C_PREP;
      done_q <= 1'b0; ovf_q <= 1'b0; dbz_q <= 1'b0;
    end else if (step_i && cnt_q != C_IDLE) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == C_PREP) begin
        rem_q  <= p_num[2*DW-1:DW];
        quo_q  <= p_num[DW-1:0];
        dmag_q <= p_dmag;
        negq_q <= p_negq; negr_q <= p_negr; sgn_q <= p_sgn;
        ovfp_q <= p_eovf & ~p_dbz;
        dbzp_q <= p_dbz;
      end else if (cnt_q == C_LAST) begin
        done_q <= 1'b1;
        dbz_q  <= dbzp_q;
        ovf_q  <= ~dbzp_q & (ovfp_q | f_lovf);
        if (!dbzp_q && !ovfp_q && !f_lovf) begin
          quot_q <= f_quo;
          remr_q <= f_rem;
        end
      end else begin
        rem_q <= s_rem;
        quo_q <= s_quo;
      end
    end
  end

  assign quot_o = 16'(quot_q);
  assign rem_o  = 16'(remr_q);
  assign done_o = done_q;
  assign ovf_o  = ovf_q;
  assign dbz_o  = dbz_q;

  // R3: completion only on a step edge
  a_r3_done_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(step_i));
  // R2: issue clears status
  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && !ovf_o && !dbz_o));
  // R10: nothing moves without a control pulse
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !step_i) |=> ($stable(quot_o) && $stable(rem_o) && $stable(done_o)));
  // R9: zero divisor leaves results untouched
  a_r9_dbz_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbz_o) |-> ($stable(quot_o) && $stable(rem_o) && !ovf_o));
  // R8: overflow leaves results untouched
  a_r8_ovf_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> ($stable(quot_o) && $stable(rem_o)));
  // R8: flags appear only with completion
  a_r8_flags_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o || dbz_o) |-> done_o);
  // R4: partial remainder stays below divisor magnitude
  a_r4_rem_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= CW'(1) && cnt_q <= C_LAST && !ovfp_q && !dbzp_q) |-> (rem_q < dmag_q));
endmodule

// File: tb/div_iter_tb.sv
module div_iter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, step = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] lo = '0, hi = '0, dvs = '0;
  logic [15:0] quot, rem;
  logic        done, ovf, dbz;

  int n_cmp = 0, n_bad = 0;

  // reference state
  logic [15:0] e_q = '0, e_r = '0;
  logic        e_done = 1'b0, e_ovf = 1'b0, e_dbz = 1'b0;
  int          e_cnt = 18;
  logic [2:0]  c_mode = '0;
  logic [15:0] c_lo = '0, c_hi = '0, c_d = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  div_iter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .step_i(step), .mode_i(mode),
    .dvd_lo_i(lo), .dvd_hi_i(hi), .dvs_i(dvs),
    .quot_o(quot), .rem_o(rem), .done_o(done), .ovf_o(ovf), .dbz_o(dbz)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (mode %0d %h_%h / %h)",
               req, what, act, exp, c_mode, c_hi, c_lo, c_d);
    end
  endtask

  function automatic void ref_div(input logic [2:0] m, input logic [15:0] l, h, d,
                                  output logic [15:0] q, r, output logic ov, dz);
    longint n, dv, qq, rr, al, ad;
    bit sg;
    case (m)
      3'd0: begin n = longint'($signed({h, l})); sg = 1; end
      3'd2: begin n = longint'($signed(l)); sg = 1; end
      3'd3: begin n = longint'(l); sg = 0; end
      3'd4: begin n = longint'($signed(l)) * 32768; sg = 1; end
      default: begin n = longint'({h, l}); sg = 0; end
    endcase
    dv = sg ? longint'($signed(d)) : longint'(d);
    dz = (d == 16'h0); ov = 1'b0; q = '0; r = '0;
    if (dz) return;
    qq = n / dv; rr = n % dv;
    if (sg) ov = (qq > 32767) || (qq < -32768);
    else    ov = (qq > 65535);
    if (m == 3'd4) begin
      al = longint'($signed(l)); if (al < 0) al = -al;
      ad = dv; if (ad < 0) ad = -ad;
      if (al >= ad) ov = 1'b1;
    end
    q = qq[15:0]; r = rr[15:0];
  endfunction

  // one clock: inputs already driven; advance model, compare after the edge
  task automatic tick(input string req);
    logic [15:0] q, r; logic ov, dz;
    @(negedge clk);
    if (start) begin
      c_mode = mode; c_lo = lo; c_hi = hi; c_d = dvs;
      e_cnt = 0; e_done = 0; e_ovf = 0; e_dbz = 0;
    end else if (step && e_cnt < 18) begin
      e_cnt++;
      if (e_cnt == 18) begin
        ref_div(c_mode, c_lo, c_hi, c_d, q, r, ov, dz);
        e_done = 1; e_dbz = dz; e_ovf = ov & ~dz;
        if (!ov && !dz) begin e_q = q; e_r = r; end
      end
    end
    chk(req, "done", 16'(done), 16'(e_done));
    chk(req, "ovf",  16'(ovf),  16'(e_ovf));
    chk(req, "dbz",  16'(dbz),  16'(e_dbz));
    chk(req, "quot", quot, e_q);
    chk(req, "rem",  rem,  e_r);
    start = 0; step = 0;
    lo = 16'($urandom); hi = 16'($urandom); dvs = 16'($urandom); mode = 3'($urandom);
  endtask

  task automatic issue(input logic [2:0] m, input logic [15:0] l, h, d, input string req);
    start = 1; mode = m; lo = l; hi = h; dvs = d;
    tick(req);
  endtask

  task automatic steps(input int n, input bit gaps, input string req);
    for (int i = 0; i < n; i++) begin
      if (gaps) begin
        int g = $urandom_range(0, 3);
        for (int k = 0; k < g; k++) tick(req);
      end
      step = 1;
      tick(req);
    end
  endtask

  task automatic run(input logic [2:0] m, input logic [15:0] l, h, d, input bit gaps, input string req);
    issue(m, l, h, d, req);
    steps(18, gaps, req);
  endtask

  function automatic logic [15:0] rand_hi();
    case ($urandom_range(0, 2))
      0: return 16'($urandom);
      1: return 16'($urandom_range(0, 255));
      default: return 16'hFF00 | 16'($urandom_range(0, 255));
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL R3 watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick("R1");                               // R1 reset state
    step = 1; tick("R1");                     // R1 step before any issue is ignored
    // R4 signed 32/16, four sign combinations
    run(3'd0, 16'h86A0, 16'h0001, 16'd7, 0, "R4");
    run(3'd0, 16'h7960, 16'hFFFE, 16'd7, 0, "R4");
    run(3'd0, 16'h86A0, 16'h0001, 16'hFFF9, 0, "R4");
    run(3'd0, 16'h7960, 16'hFFFE, 16'hFFF9, 0, "R4");
    run(3'd0, 16'h0000, 16'h8000, 16'hFFFF, 0, "R8");  // R8 -2^31 / -1
    // R5 unsigned 32/16
    run(3'd1, 16'hFFFF, 16'hFFFE, 16'hFFFF, 0, "R5");
    run(3'd1, 16'hFFFF, 16'hFFFF, 16'h0001, 0, "R8");  // R8 max over 1
    run(3'd6, 16'h1234, 16'h0005, 16'h0100, 0, "R5");  // R5 reserved mode
    // R6 16/16
    run(3'd3, 16'hFFFF, 16'hABCD, 16'h0001, 0, "R6");
    run(3'd2, 16'h8000, 16'h1234, 16'h0001, 0, "R6");
    run(3'd2, 16'h8000, 16'h0000, 16'hFFFF, 0, "R8");  // R8 -32768 / -1
    // R7 fractional
    run(3'd4, 16'h2000, 16'h0000, 16'h4000, 0, "R7");
    run(3'd4, 16'hE000, 16'h0000, 16'h4000, 0, "R7");
    run(3'd4, 16'h4000, 16'h0000, 16'hC000, 0, "R8");
    // R9 zero divisor
    run(3'd0, 16'h1111, 16'h0000, 16'h0000, 0, "R9");
    // R10 extra steps after done
    steps(4, 0, "R10");
    // R3 short sequence with long pause, then completion
    issue(3'd1, 16'h5555, 16'h0002, 16'h0033, "R3");
    steps(17, 0, "R3");
    repeat (40) tick("R3");
    steps(1, 0, "R3");
    // R2 restart mid-sequence
    issue(3'd0, 16'h0001, 16'h0000, 16'h0003, "R2");
    steps(7, 0, "R2");
    run(3'd2, 16'hFF9C, 16'h0000, 16'h0007, 0, "R2");
    // random per mode, with and without gaps
    for (int m = 0; m < 5; m++) begin
      for (int i = 0; i < 150; i++) begin
        logic [15:0] d = 16'($urandom);
        if ($urandom_range(0, 3) == 0) d = 16'($urandom_range(1, 255));
        run(3'(m), 16'($urandom), rand_hi(), d, bit'(i[0]),
            m == 0 ? "R4" : m == 1 ? "R5" : m == 4 ? "R7" : "R6");
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule